// File: doc/BRIEF.md
# Frame-Synchronised Colour Lookup Store

This block keeps a 64-entry colour lookup table. The video pixel pipeline reads it on every clock. For each pixel, or for the border while the beam is outside the active area, the pipeline presents a 6-bit slot number. One clock later it receives the stored 8-bit colour code. Each code is packed with red in bits [7:5], green in bits [4:2] and blue in bits [1:0]. The block passes the code through unchanged.

The processor changes a colour in two port writes. The first write selects a slot. The second write supplies the colour code. The store does not write the table at once. It holds the data write in a single-entry cue and commits it only inside a safe window, so the colour stream never breaks in the middle of a frame. Two window choices exist:

- In frame mode the window is vertical sync.
- In line mode the window is horizontal flyback, so the new colour applies to the whole next line.

While a write waits in the cue, the processor is stalled with a wait signal. The commit takes one clock. In that clock the table skips its lookup and the output stage keeps showing the previous colour.

Top module: `pal_sync_store`

## Requirements
- R1: The table holds 64 slots of 8-bit codes (red [7:5], green [4:2], blue [1:0]). A code written to a slot is later returned bit-exact on `pix_color`. `pix_color` shows the code of the slot that `pix_idx` held at the previous rising clock edge.
- R2: A slot-select write (`cpu_idx_we`) takes the slot number from `cpu_wdata[5:0]` and ignores bits [7:6]. The selected slot is kept, so further data writes without a new select go to the same slot.
- R3: With `line_mode` = 0, a cued write is committed only at a clock edge where `vsync` is high. `hblank` has no effect in this mode.
- R4: With `line_mode` = 1, a cued write is committed only at a clock edge where `hblank` is high. `vsync` has no effect in this mode.
- R5: `cpu_wait` goes high in the clock after an accepted data write. It stays high until the commit edge and is low right after that edge, including when the window is already open at the time of the data write.
- R6: Only one write is cued at a time. A data write that arrives while a write is cued is ignored: the cued code is committed, and no second commit or wait period follows.
- R7: At the commit edge `pix_color` keeps its previous value, whatever `pix_idx` holds. At the next edge, lookup resumes.
- R8: An active-low reset clears every slot to zero, cancels a cued write, drives `cpu_wait` low and clears `pix_color`. A write cued before the reset is never committed afterwards.
- R9: A cued write goes to the slot that was selected when the data write was accepted. A slot-select write made while the write is cued does not redirect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_idx | input | 6 | Slot number for the pixel or border lookup |
| pix_color | output | 8 | Looked-up colour code, one clock after `pix_idx` |
| cpu_idx_we | input | 1 | Slot-select write strobe |
| cpu_data_we | input | 1 | Colour data write strobe |
| cpu_wdata | input | 8 | Processor write data (slot number or colour code) |
| line_mode | input | 1 | 0: commit in vertical sync, 1: commit in horizontal flyback |
| vsync | input | 1 | Vertical sync window from the timing generator |
| hblank | input | 1 | Horizontal flyback window from the timing generator |
| cpu_wait | output | 1 | Processor stall while a write is cued |

## Verification
A corrupted cue shows up at the ports in one of these ways:
- `cpu_wait` stays stuck.
- `cpu_wait` drops outside the selected window.
- The colour lands in the wrong slot, which shows on the first lookup of that slot after the commit.

A fault in the commit hold shows as a changed `pix_color` in the exact commit clock. A fault in a storage slot shows one clock after that slot is looked up. The bench therefore reads back every written slot and its neighbours right after each window. It also counts wait cycles edge by edge, so an early or late release is caught in the cycle it happens.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int PAL_ENTRIES = 64;
  localparam int PAL_CW      = 8;

  typedef enum logic {
    WIN_FRAME = 1'b0,
    WIN_LINE  = 1'b1
  } win_sel_e;
endpackage

// File: rtl/pal_cue.sv
module pal_cue #(
  parameter int ENTRIES = pal_pkg::PAL_ENTRIES,
  parameter int CW      = pal_pkg::PAL_CW,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_we,
  input  logic          data_we,
  input  logic [CW-1:0] wdata,
  input  logic          commit,
  output logic          cue_live,
  output logic [IW-1:0] cue_slot,
  output logic [CW-1:0] cue_code
);
  logic [IW-1:0] sel_q, sel_d;
  logic          sel_en;
  logic          live_q, live_d;
  logic [IW-1:0] slot_q, slot_d;
  logic [CW-1:0] code_q, code_d;
  logic          cue_en;
  logic          accept;

  // next state
  always_comb begin
    accept = data_we && !live_q;
    sel_en = idx_we;
    sel_d  = wdata[IW-1:0];
    cue_en = commit || accept;
    live_d = live_q;
    slot_d = slot_q;
    code_d = code_q;
    if (commit) begin
      live_d = 1'b0;
    end else if (accept) begin
      live_d = 1'b1;
      slot_d = sel_q;
      code_d = wdata;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      slot_q <= '0;
      code_q <= '0;
    end else if (cue_en) begin
      live_q <= live_d;
      slot_q <= slot_d;
      code_q <= code_d;
    end
  end

  assign cue_live = live_q;
  assign cue_slot = slot_q;
  assign cue_code = code_q;

  // a cued write stays frozen until its commit
  assert_cue_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !commit) |=> (live_q && $stable(code_q) && $stable(slot_q)));

  // the commit empties the cue
  assert_cue_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !live_q);

  // the target slot is the one selected before acceptance
  assert_cue_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !live_q) |=> (slot_q == $past(sel_q)));
endmodule

// File: rtl/pal_window.sv
module pal_window
  import pal_pkg::*;
#(
  parameter bit LINE_EN = 1'b1
) (
  input  win_sel_e mode,
  input  logic     vsync,
  input  logic     hblank,
  input  logic     cue_live,
  output logic     commit
);
  logic open_w;

  if (LINE_EN) begin : g_both
    always_comb open_w = (mode == WIN_LINE) ? hblank : vsync;
  end else begin : g_frame
    logic unused_sel;
    assign unused_sel = ^{mode, hblank};
    always_comb open_w = vsync;
  end

  always_comb commit = cue_live && open_w;
endmodule

// File: rtl/pal_table.sv
module pal_table #(
  parameter int ENTRIES = pal_pkg::PAL_ENTRIES,
  parameter int CW      = pal_pkg::PAL_CW,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [CW-1:0] wcode,
  input  logic [IW-1:0] rd_idx,
  input  logic          hold,
  output logic [CW-1:0] rd_code
);
  logic [CW-1:0] slot_w [ENTRIES];
  logic [CW-1:0] rd_sel;
  logic [CW-1:0] out_q, out_d;
  logic          out_en;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic [CW-1:0] code_q, code_d;
    logic          hit;

    always_comb begin
      hit    = we && (waddr == IW'(g));
      code_d = wcode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q <= '0;
      end else if (hit) begin
        code_q <= code_d;
      end
    end

    assign slot_w[g] = code_q;
  end

  // lookup path; skipped in the commit clock
  always_comb begin
    rd_sel = slot_w[rd_idx];
    out_en = !hold;
    out_d  = rd_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

  assign rd_code = out_q;

  assert_commit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(rd_code));
endmodule

// File: rtl/pal_sync_store.sv
module pal_sync_store
  import pal_pkg::*;
#(
  parameter int ENTRIES = PAL_ENTRIES,
  parameter int CW      = PAL_CW,
  parameter bit LINE_EN = 1'b1,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] pix_idx,
  output logic [CW-1:0] pix_color,
  input  logic          cpu_idx_we,
  input  logic          cpu_data_we,
  input  logic [CW-1:0] cpu_wdata,
  input  logic          line_mode,
  input  logic          vsync,
  input  logic          hblank,
  output logic          cpu_wait
);
  logic [1:0]    rst_sync_q;
  logic          rst_sn;
  logic          commit;
  logic          cue_live;
  logic [IW-1:0] cue_slot;
  logic [CW-1:0] cue_code;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sn = rst_sync_q[1];

  pal_cue #(.ENTRIES(ENTRIES), .CW(CW)) i_cue (
    .clk      (clk),
    .rst_n    (rst_sn),
    .idx_we   (cpu_idx_we),
    .data_we  (cpu_data_we),
    .wdata    (cpu_wdata),
    .commit   (commit),
    .cue_live (cue_live),
    .cue_slot (cue_slot),
    .cue_code (cue_code)
  );

  pal_window #(.LINE_EN(LINE_EN)) i_window (
    .mode     (win_sel_e'(line_mode)),
    .vsync    (vsync),
    .hblank   (hblank),
    .cue_live (cue_live),
    .commit   (commit)
  );

  pal_table #(.ENTRIES(ENTRIES), .CW(CW)) i_table (
    .clk     (clk),
    .rst_n   (rst_sn),
    .we      (commit),
    .waddr   (cue_slot),
    .wcode   (cue_code),
    .rd_idx  (pix_idx),
    .hold    (commit),
    .rd_code (pix_color)
  );

  assign cpu_wait = cue_live;

  // wait may only end inside the frame window in frame mode
  assert_frame_window_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    ($fell(cpu_wait) && (!LINE_EN || !$past(line_mode))) |-> $past(vsync));

  // wait may only end inside the line window in line mode
  assert_line_window_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    ($fell(cpu_wait) && LINE_EN && $past(line_mode)) |-> $past(hblank));

  // an accepted data write raises the stall in the next clock
  assert_wait_rise_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (cpu_data_we && !cpu_wait) |=> cpu_wait);
endmodule

// File: tb/test_pal_sync_store.sv
module test_pal_sync_store;
  logic       clk;
  logic       rst_n;
  logic [5:0] pix_idx;
  logic [7:0] pix_color;
  logic       cpu_idx_we;
  logic       cpu_data_we;
  logic [7:0] cpu_wdata;
  logic       line_mode;
  logic       vsync;
  logic       hblank;
  logic       cpu_wait;

  int   n_run;
  int   n_fail;
  bit   done;

  logic [7:0] mdl [64];
  logic [7:0] last_exp;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  pal_sync_store i_pal_sync_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_idx     (pix_idx),
    .pix_color   (pix_color),
    .cpu_idx_we  (cpu_idx_we),
    .cpu_data_we (cpu_data_we),
    .cpu_wdata   (cpu_wdata),
    .line_mode   (line_mode),
    .vsync       (vsync),
    .hblank      (hblank),
    .cpu_wait    (cpu_wait)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic push_exp(logic [7:0] v, string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
    last_exp = v;
  endtask

  // scoreboard monitor: one expected item per edge after a push
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, pix_color, e);
      end
    end
  end

  task automatic rd(logic [5:0] idx, string tag);
    @(negedge clk);
    pix_idx = idx;
    push_exp(mdl[idx], tag);
  endtask

  task automatic wr_idx(logic [7:0] v);
    @(negedge clk);
    cpu_idx_we = 1'b1;
    cpu_wdata  = v;
    @(negedge clk);
    cpu_idx_we = 1'b0;
  endtask

  task automatic wr_data(logic [7:0] d, string tag);
    @(negedge clk);
    cpu_data_we = 1'b1;
    cpu_wdata   = d;
    @(negedge clk);
    cpu_data_we = 1'b0;
    chk(tag, {7'd0, cpu_wait}, 8'd1);
  endtask

  // opens the frame window for exactly one edge
  task automatic open_frame(string tag);
    @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    chk(tag, {7'd0, cpu_wait}, 8'd0);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0;
    n_fail = 0;
    done = 1'b0;
    last_exp = 8'h00;
    foreach (mdl[i]) mdl[i] = 8'h00;
    rst_n = 1'b0;
    pix_idx = '0;
    cpu_idx_we = 1'b0;
    cpu_data_we = 1'b0;
    cpu_wdata = '0;
    line_mode = 1'b0;
    vsync = 1'b0;
    hblank = 1'b0;
    #1;
    chk("R8 wait in reset", {7'd0, cpu_wait}, 8'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 wait after reset", {7'd0, cpu_wait}, 8'd0);
    rd(6'd0, "R8 slot 0 cleared");
    rd(6'd63, "R8 slot 63 cleared");
    rd(6'd17, "R8 slot 17 cleared");
    drain();

    // frame mode: cued until vsync, hblank ignored (R3)
    wr_idx(8'h09);
    wr_data(8'h3C, "R5 wait after data write");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R3 no commit without vsync", {7'd0, cpu_wait}, 8'd1);
    end
    rd(6'd9, "R3 slot unchanged before window");
    @(negedge clk);
    hblank = 1'b1;
    @(negedge clk);
    hblank = 1'b0;
    chk("R3 hblank ignored in frame mode", {7'd0, cpu_wait}, 8'd1);
    drain();
    open_frame("R5 wait released at vsync");
    mdl[9] = 8'h3C;
    rd(6'd9, "R1 code returned");
    drain();

    // output holds in the commit clock (R7)
    wr_idx(8'h02);
    wr_data(8'h81, "R5 wait after data write");
    @(negedge clk);
    pix_idx = 6'd0;
    vsync = 1'b1;
    push_exp(last_exp, "R7 hold during commit");
    @(negedge clk);
    vsync = 1'b0;
    chk("R5 wait released", {7'd0, cpu_wait}, 8'd0);
    mdl[2] = 8'h81;
    push_exp(mdl[0], "R7 lookup resumes");
    rd(6'd2, "R1 committed slot 2");
    rd(6'd1, "R1 neighbour slot 1");
    drain();

    // line mode (R4)
    line_mode = 1'b1;
    wr_idx(8'd40);
    wr_data(8'h5B, "R5 wait after data write");
    @(negedge clk);
    vsync = 1'b1;
    repeat (3) @(negedge clk);
    vsync = 1'b0;
    chk("R4 vsync ignored in line mode", {7'd0, cpu_wait}, 8'd1);
    rd(6'd40, "R4 slot unchanged before flyback");
    @(negedge clk);
    hblank = 1'b1;
    @(negedge clk);
    hblank = 1'b0;
    chk("R4 commit at flyback", {7'd0, cpu_wait}, 8'd0);
    mdl[40] = 8'h5B;
    rd(6'd40, "R4 line commit value");
    drain();
    line_mode = 1'b0;

    // second write while cued is ignored (R6)
    wr_idx(8'd10);
    wr_data(8'h11, "R5 wait after data write");
    wr_data(8'h22, "R6 still waiting");
    open_frame("R6 single commit");
    @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    chk("R6 no second cued write", {7'd0, cpu_wait}, 8'd0);
    mdl[10] = 8'h11;
    rd(6'd10, "R6 first code kept");
    drain();

    // re-select while cued does not redirect (R9), select persists (R2)
    wr_idx(8'd20);
    wr_data(8'h44, "R5 wait after data write");
    wr_idx(8'd21);
    open_frame("R9 commit");
    mdl[20] = 8'h44;
    rd(6'd20, "R9 written to original slot");
    rd(6'd21, "R9 new slot untouched");
    wr_data(8'h66, "R5 wait after data write");
    open_frame("R2 commit");
    mdl[21] = 8'h66;
    rd(6'd21, "R2 select persists");
    rd(6'd20, "R2 previous slot kept");
    drain();

    // upper select bits ignored (R2), boundary slots
    wr_idx(8'hFF);
    wr_data(8'hFF, "R5 wait after data write");
    open_frame("R2 commit");
    mdl[63] = 8'hFF;
    rd(6'd63, "R2 select FF maps to slot 63");
    wr_idx(8'h40);
    wr_data(8'h01, "R5 wait after data write");
    open_frame("R2 commit");
    mdl[0] = 8'h01;
    rd(6'd0, "R2 select 40 maps to slot 0");
    drain();

    // window already open at data write (R5)
    wr_idx(8'd30);
    @(negedge clk);
    vsync = 1'b1;
    wr_data(8'h99, "R5 wait one clock in open window");
    @(negedge clk);
    chk("R5 release in open window", {7'd0, cpu_wait}, 8'd0);
    vsync = 1'b0;
    mdl[30] = 8'h99;
    rd(6'd30, "R5 open window value");
    drain();

    // pattern of writes, then read back
    for (int i = 0; i < 8; i++) begin
      logic [5:0] s;
      logic [7:0] d;
      s = 6'((i * 7 + 3) % 64);
      d = 8'((i * 37) ^ 8'h5A);
      wr_idx({2'b00, s});
      wr_data(d, "R5 wait after data write");
      open_frame("R3 pattern commit");
      mdl[s] = d;
    end
    for (int i = 0; i < 8; i++) begin
      rd(6'((i * 7 + 3) % 64), "R1 pattern readback");
    end
    drain();

    // reset cancels a cued write (R8)
    wr_idx(8'd5);
    wr_data(8'h77, "R5 wait after data write");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 wait cleared by reset", {7'd0, cpu_wait}, 8'd0);
    chk("R8 output cleared by reset", pix_color, 8'h00);
    foreach (mdl[i]) mdl[i] = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    vsync = 1'b1;
    repeat (2) @(negedge clk);
    vsync = 1'b0;
    chk("R8 no stale wait", {7'd0, cpu_wait}, 8'd0);
    rd(6'd5, "R8 cued write dropped");
    rd(6'd9, "R8 slot 9 cleared");
    rd(6'd63, "R8 slot 63 cleared");
    drain();
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule